// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a display panel from a small set of configuration values: active width and height, horizontal and vertical totals, sync widths, polarity controls, and an interlace flag. The back-porch values are the sync width and the back porch added together, and both are measured from the start of sync. The block drives hsync, vsync, a data-enable, pixel x/y coordinates inside the active window, a line-start strobe delayed by a computed clock-delay value, a field indicator and a per-field vblank pulse.

A parameter selects one of two channel variants. The panel variant counts its vertical total in whole lines. The TV/scaler variant counts its vertical total in half-line units, so a progressive mode is written with twice its line count. Both variants support interlace. In interlaced mode the active height of each field is half the programmed height. The clock-delay value is derived from the vertical blanking and saturates at 30.

Configuration inputs are copied into shadow registers. While the channel is disabled they are copied every cycle. While it runs they are copied only at a frame boundary, so a frame is never torn. While the channel is disabled, every pad output is held low and the output-enable is low, which tristates the pads.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset and while `chanEn` is low, `outEn`, `hsync`, `vsync`, `de`, `pixX`, `pixY`, `lineStart`, `field` and `vblankIrq` are all 0.
- R2: In the first cycle after `chanEn` is sampled high, the outputs show pixel position x=0 of line 0. Position x advances by one each cycle and wraps after `cfgHTotal` cycles. `outEn` is 1 while running. Un-inverted hsync is high for x < `cfgHSyncW`.
- R3: `de` is high exactly when `cfgHBackPorch` <= x < `cfgHBackPorch`+`cfgActiveW` and `cfgVBackPorch` <= y < `cfgVBackPorch`+activeLines. Here y is the line within the current field, and activeLines is `cfgActiveH`, or `cfgActiveH`/2 when interlaced. While `de` is high, `pixX` = x-`cfgHBackPorch` and `pixY` = y-`cfgVBackPorch`. Otherwise both are 0. The configuration must keep `cfgHBackPorch`+`cfgActiveW` < `cfgHTotal`, and the vertical active window must fit inside the field.
- R4: In progressive mode a frame has `cfgVTotal` lines on the panel variant and `cfgVTotal`/2 lines on the TV variant, because the TV variant counts half-lines. Un-inverted vsync is high for lines y < `cfgVSyncW`.
- R5: `cfgHInvert` inverts hsync and `cfgVInvert` inverts vsync, each on its own. `cfgForceHigh`=1 cancels both inversions.
- R6: `clkDelay` is computed in four steps. First, L-`cfgActiveH`, where L is the frame line count: `cfgVTotal`, except on the TV variant in progressive mode, where it is `cfgVTotal`/2. Second, the result is halved (rounding down) when interlaced. Third, 2 is subtracted on the TV variant. Fourth, the result is limited to the range 0 to 30.
- R7: `lineStart` is high for one cycle on every line, at the position x = `clkDelay`.
- R8: In interlaced mode a frame has two fields. Field 0 has (`cfgVTotal`+1)/2 lines and field 1 has `cfgVTotal`/2 lines. `field` is 0 during field 0 and 1 during field 1, and y restarts at 0 in each field.
- R9: A configuration change made while the channel runs does not take effect until the end of the current frame. The new timing starts at x=0, line 0 of the next frame.
- R10: When `irqEn` is high, `vblankIrq` pulses for one cycle at x=0 of line y = `cfgVBackPorch`+activeLines in each field. When `irqEn` is low, it never pulses.
- R11: Lowering `chanEn` returns all outputs to the R1 state one cycle later. Raising it again restarts timing at x=0, line 0, field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEn | input | 1 | Channel enable |
| irqEn | input | 1 | Vblank pulse enable |
| cfgActiveW | input | HW | Active pixels per line |
| cfgActiveH | input | VW | Active lines per frame |
| cfgHTotal | input | HW | Pixel clocks per line |
| cfgHBackPorch | input | HW | Sync width plus horizontal back porch |
| cfgHSyncW | input | HW | Hsync width in pixels |
| cfgVTotal | input | VW | Vertical total (lines, or half-lines on the TV variant) |
| cfgVBackPorch | input | VW | Sync width plus vertical back porch, in lines |
| cfgVSyncW | input | VW | Vsync width in lines |
| cfgHInvert | input | 1 | Invert hsync |
| cfgVInvert | input | 1 | Invert vsync |
| cfgForceHigh | input | 1 | Cancel both inversions |
| cfgInterlace | input | 1 | Interlaced scan |
| outEn | output | 1 | Pad drive enable (0 = tristate) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixX | output | HW | Pixel column inside the active window |
| pixY | output | VW | Line inside the active window of the field |
| lineStart | output | 1 | Delayed line-start strobe |
| field | output | 1 | Current field (0 or 1) |
| vblankIrq | output | 1 | Vblank pulse |
| clkDelay | output | DW | Computed clock-delay value |

## Verification
An error in the horizontal counter or its wrap point shows up within one line. The hsync, `de` and `lineStart` positions would move, and `pixX` would skip a step. An error in the vertical or field counter appears at the first field end as a shifted vsync, `vblankIrq` or `field` edge. A shadow register that loads at the wrong moment changes the line length in the middle of a frame. Comparing every output each cycle against positions computed arithmetically from the elapsed cycle count detects any of these errors in the cycle where it occurs, on both channel variants.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic drive;    // channel running, pads driven
    logic advance;  // step the raster counters this cycle
    logic clear;    // return counters and field to the origin
    logic load;     // copy configuration inputs into the shadow set
  } tgStrobe_t;

  typedef enum logic {
    TG_IDLE = 1'b0,
    TG_RUN  = 1'b1
  } tgState_t;

endpackage

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_tg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chanEn,
  input  logic      frameEnd,
  output tgStrobe_t strobe
);

  tgState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= TG_IDLE;
    else       state <= chanEn ? TG_RUN : TG_IDLE;
  end

  always_comb begin
    strobe.drive   = (state == TG_RUN);
    strobe.advance = strobe.drive && chanEn;
    strobe.clear   = !strobe.advance;
    // Idle: shadow follows the inputs; running: only at the frame wrap
    strobe.load    = !strobe.drive || (strobe.advance && frameEnd);
  end

endmodule

// File: rtl/lcd_tg_datapath.sv
module lcd_tg_datapath
  import lcd_tg_pkg::*;
#(
  parameter int HW        = 12,
  parameter int VW        = 12,
  parameter int IS_TV     = 0,
  parameter int DELAY_MAX = 30,
  parameter int DW        = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  tgStrobe_t     strobe,
  input  logic          irqEn,
  input  logic [HW-1:0] cfgActiveW,
  input  logic [VW-1:0] cfgActiveH,
  input  logic [HW-1:0] cfgHTotal,
  input  logic [HW-1:0] cfgHBackPorch,
  input  logic [HW-1:0] cfgHSyncW,
  input  logic [VW-1:0] cfgVTotal,
  input  logic [VW-1:0] cfgVBackPorch,
  input  logic [VW-1:0] cfgVSyncW,
  input  logic          cfgHInvert,
  input  logic          cfgVInvert,
  input  logic          cfgForceHigh,
  input  logic          cfgInterlace,
  output logic          frameEnd,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pixX,
  output logic [VW-1:0] pixY,
  output logic          lineStart,
  output logic          field,
  output logic          vblankIrq,
  output logic [DW-1:0] clkDelay
);

  localparam int TV_ADJ = (IS_TV != 0) ? 2 : 0;
  localparam int SW     = VW + 2;

  // Shadow configuration
  logic [HW-1:0] sActW, sHTot, sHBp, sHSw;
  logic [VW-1:0] sActH, sVTot, sVBp, sVSw;
  logic          sHInv, sVInv, sForce, sIntl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sActW <= '0; sHTot <= '0; sHBp <= '0; sHSw <= '0;
      sActH <= '0; sVTot <= '0; sVBp <= '0; sVSw <= '0;
      sHInv <= 1'b0; sVInv <= 1'b0; sForce <= 1'b0; sIntl <= 1'b0;
    end else if (strobe.load) begin
      sActW  <= cfgActiveW;
      sHTot  <= cfgHTotal;
      sHBp   <= cfgHBackPorch;
      sHSw   <= cfgHSyncW;
      sActH  <= cfgActiveH;
      sVTot  <= cfgVTotal;
      sVBp   <= cfgVBackPorch;
      sVSw   <= cfgVSyncW;
      sHInv  <= cfgHInvert;
      sVInv  <= cfgVInvert;
      sForce <= cfgForceHigh;
      sIntl  <= cfgInterlace;
    end
  end

  // Channel variant: how the vertical total register is interpreted
  logic [VW-1:0] progLines;
  logic [VW-1:0] frameLinesD;

  if (IS_TV != 0) begin : g_tvChan
    assign progLines   = sVTot >> 1;
    assign frameLinesD = sIntl ? sVTot : (sVTot >> 1);
  end else begin : g_panelChan
    assign progLines   = sVTot;
    assign frameLinesD = sVTot;
  end

  // Raster counters
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          fieldQ;
  logic [VW-1:0] fieldLines;
  logic [VW-1:0] actLines;
  logic          lastPix, lastLine;

  always_comb begin
    if (sIntl)
      fieldLines = fieldQ ? (sVTot >> 1)
                          : ((sVTot >> 1) + {{(VW-1){1'b0}}, sVTot[0]});
    else
      fieldLines = progLines;
    actLines = sIntl ? (sActH >> 1) : sActH;
  end

  assign lastPix  = (hCnt == sHTot - 1'b1);
  assign lastLine = (vCnt == fieldLines - 1'b1);
  assign frameEnd = lastPix && lastLine && (!sIntl || fieldQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt   <= '0;
      vCnt   <= '0;
      fieldQ <= 1'b0;
    end else if (strobe.clear) begin
      hCnt   <= '0;
      vCnt   <= '0;
      fieldQ <= 1'b0;
    end else if (strobe.advance) begin
      if (lastPix) begin
        hCnt <= '0;
        if (lastLine) begin
          vCnt   <= '0;
          fieldQ <= sIntl ? ~fieldQ : 1'b0;
        end else begin
          vCnt <= vCnt + 1'b1;
        end
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  // Clock delay from the vertical blanking, saturating
  logic signed [SW-1:0] blank;
  logic [DW-1:0]        delayVal;

  always_comb begin
    blank = $signed({2'b00, frameLinesD}) - $signed({2'b00, sActH});
    if (sIntl) blank = blank >>> 1;
    blank = blank - $signed(SW'(TV_ADJ));
    if (blank < 0)
      delayVal = '0;
    else if (blank > $signed(SW'(DELAY_MAX)))
      delayVal = DW'(DELAY_MAX);
    else
      delayVal = blank[DW-1:0];
  end

  assign clkDelay = delayVal;

  // Region decode
  logic hSyncRaw, vSyncRaw, hAct, vAct, invH, invV;

  always_comb begin
    hSyncRaw = (hCnt < sHSw);
    vSyncRaw = (vCnt < sVSw);
    hAct = (hCnt >= sHBp) &&
           ({1'b0, hCnt} < ({1'b0, sHBp} + {1'b0, sActW}));
    vAct = (vCnt >= sVBp) &&
           ({1'b0, vCnt} < ({1'b0, sVBp} + {1'b0, actLines}));
    invH = sHInv & ~sForce;
    invV = sVInv & ~sForce;
  end

  assign hsync     = strobe.drive & (hSyncRaw ^ invH);
  assign vsync     = strobe.drive & (vSyncRaw ^ invV);
  assign de        = strobe.drive & hAct & vAct;
  assign pixX      = de ? (hCnt - sHBp) : '0;
  assign pixY      = de ? (vCnt - sVBp) : '0;
  assign lineStart = strobe.drive & (hCnt == HW'(delayVal));
  assign field     = strobe.drive & fieldQ;
  assign vblankIrq = strobe.drive & irqEn & (hCnt == '0) &
                     ({1'b0, vCnt} == ({1'b0, sVBp} + {1'b0, actLines}));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int HW        = 12,
  parameter int VW        = 12,
  parameter int IS_TV     = 0,
  parameter int DELAY_MAX = 30
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chanEn,
  input  logic          irqEn,
  input  logic [HW-1:0] cfgActiveW,
  input  logic [VW-1:0] cfgActiveH,
  input  logic [HW-1:0] cfgHTotal,
  input  logic [HW-1:0] cfgHBackPorch,
  input  logic [HW-1:0] cfgHSyncW,
  input  logic [VW-1:0] cfgVTotal,
  input  logic [VW-1:0] cfgVBackPorch,
  input  logic [VW-1:0] cfgVSyncW,
  input  logic          cfgHInvert,
  input  logic          cfgVInvert,
  input  logic          cfgForceHigh,
  input  logic          cfgInterlace,
  output logic          outEn,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pixX,
  output logic [VW-1:0] pixY,
  output logic          lineStart,
  output logic          field,
  output logic          vblankIrq,
  output logic [$clog2(DELAY_MAX+1)-1:0] clkDelay
);

  localparam int DW = $clog2(DELAY_MAX + 1);

  tgStrobe_t strobe;
  logic      frameEnd;

  lcd_tg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chanEn   (chanEn),
    .frameEnd (frameEnd),
    .strobe   (strobe)
  );

  lcd_tg_datapath #(
    .HW(HW), .VW(VW), .IS_TV(IS_TV), .DELAY_MAX(DELAY_MAX), .DW(DW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .irqEn         (irqEn),
    .cfgActiveW    (cfgActiveW),
    .cfgActiveH    (cfgActiveH),
    .cfgHTotal     (cfgHTotal),
    .cfgHBackPorch (cfgHBackPorch),
    .cfgHSyncW     (cfgHSyncW),
    .cfgVTotal     (cfgVTotal),
    .cfgVBackPorch (cfgVBackPorch),
    .cfgVSyncW     (cfgVSyncW),
    .cfgHInvert    (cfgHInvert),
    .cfgVInvert    (cfgVInvert),
    .cfgForceHigh  (cfgForceHigh),
    .cfgInterlace  (cfgInterlace),
    .frameEnd      (frameEnd),
    .hsync         (hsync),
    .vsync         (vsync),
    .de            (de),
    .pixX          (pixX),
    .pixY          (pixY),
    .lineStart     (lineStart),
    .field         (field),
    .vblankIrq     (vblankIrq),
    .clkDelay      (clkDelay)
  );

  assign outEn = strobe.drive;

endmodule

// File: rtl/lcd_timing_gen_checker.sv
module lcd_timing_gen_checker #(
  parameter int HW        = 12,
  parameter int DW        = 5,
  parameter int DELAY_MAX = 30
) (
  input logic          clk,
  input logic          rstN,
  input logic          chanEn,
  input logic          outEn,
  input logic          de,
  input logic          field,
  input logic          vblankIrq,
  input logic [HW-1:0] pixX,
  input logic [DW-1:0] clkDelay
);

  // R11: a disabled channel is quiet on the next cycle
  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (!outEn && !de && !field));

  // R3: data enable only while pads are driven
  assert_de_driven_R3: assert property (@(posedge clk) disable iff (!rstN)
    de |-> outEn);

  // R3: consecutive active pixels step the column by one
  assert_pix_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    de |=> (!de || (pixX == $past(pixX) + 1'b1)));

  // R10: vblank pulse lasts one cycle and lies outside the active window
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    vblankIrq |=> !vblankIrq);

  assert_irq_blank_R10: assert property (@(posedge clk) disable iff (!rstN)
    vblankIrq |-> !de);

  // R6: clock delay never exceeds its ceiling
  assert_delay_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkDelay <= DW'(DELAY_MAX));

endmodule

bind lcd_timing_gen lcd_timing_gen_checker #(
  .HW(HW), .DW(DW), .DELAY_MAX(DELAY_MAX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanEn    (chanEn),
  .outEn     (outEn),
  .de        (de),
  .field     (field),
  .vblankIrq (vblankIrq),
  .pixX      (pixX),
  .clkDelay  (clkDelay)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;

  localparam int HW = 12;
  localparam int VW = 12;
  localparam int DW = 5;

  typedef struct {
    int actW, actH, hTot, hBp, hSw, vTot, vBp, vSw;
    int hInv, vInv, forceHi, intl, irq;
  } cfg_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0;
  cfg_t cur;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  logic [HW-1:0] cActW, cHTot, cHBp, cHSw;
  logic [VW-1:0] cActH, cVTot, cVBp, cVSw;
  logic cHInv, cVInv, cForce, cIntl, cIrq;

  assign cActW  = HW'(cur.actW);
  assign cHTot  = HW'(cur.hTot);
  assign cHBp   = HW'(cur.hBp);
  assign cHSw   = HW'(cur.hSw);
  assign cActH  = VW'(cur.actH);
  assign cVTot  = VW'(cur.vTot);
  assign cVBp   = VW'(cur.vBp);
  assign cVSw   = VW'(cur.vSw);
  assign cHInv  = cur.hInv[0];
  assign cVInv  = cur.vInv[0];
  assign cForce = cur.forceHi[0];
  assign cIntl  = cur.intl[0];
  assign cIrq   = cur.irq[0];

  logic pOutEn, pHs, pVs, pDe, pLs, pFld, pIrq;
  logic tOutEn, tHs, tVs, tDe, tLs, tFld, tIrq;
  logic [HW-1:0] pPixX, tPixX;
  logic [VW-1:0] pPixY, tPixY;
  logic [DW-1:0] pDly, tDly;

  lcd_timing_gen #(.HW(HW), .VW(VW), .IS_TV(0)) u_dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .irqEn(cIrq),
    .cfgActiveW(cActW), .cfgActiveH(cActH), .cfgHTotal(cHTot),
    .cfgHBackPorch(cHBp), .cfgHSyncW(cHSw), .cfgVTotal(cVTot),
    .cfgVBackPorch(cVBp), .cfgVSyncW(cVSw), .cfgHInvert(cHInv),
    .cfgVInvert(cVInv), .cfgForceHigh(cForce), .cfgInterlace(cIntl),
    .outEn(pOutEn), .hsync(pHs), .vsync(pVs), .de(pDe), .pixX(pPixX),
    .pixY(pPixY), .lineStart(pLs), .field(pFld), .vblankIrq(pIrq),
    .clkDelay(pDly)
  );

  lcd_timing_gen #(.HW(HW), .VW(VW), .IS_TV(1)) u_dutTv (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .irqEn(cIrq),
    .cfgActiveW(cActW), .cfgActiveH(cActH), .cfgHTotal(cHTot),
    .cfgHBackPorch(cHBp), .cfgHSyncW(cHSw), .cfgVTotal(cVTot),
    .cfgVBackPorch(cVBp), .cfgVSyncW(cVSw), .cfgHInvert(cHInv),
    .cfgVInvert(cVInv), .cfgForceHigh(cForce), .cfgInterlace(cIntl),
    .outEn(tOutEn), .hsync(tHs), .vsync(tVs), .de(tDe), .pixX(tPixX),
    .pixY(tPixY), .lineStart(tLs), .field(tFld), .vblankIrq(tIrq),
    .clkDelay(tDly)
  );

  task automatic chk(input string tag, input string ctx, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", tag, ctx, act, exp);
    end
  endtask

  function automatic int expDelay(input bit isTv, input cfg_t c);
    int lines, d;
    if (isTv && !c.intl) lines = c.vTot / 2;
    else                 lines = c.vTot;
    d = lines - c.actH;
    if (c.intl) d = d / 2;
    if (isTv) d = d - 2;
    if (d < 0) d = 0;
    if (d > 30) d = 30;
    return d;
  endfunction

  function automatic int frameCycles(input bit isTv, input cfg_t c);
    int lines;
    if (c.intl)    lines = c.vTot;
    else if (isTv) lines = c.vTot / 2;
    else           lines = c.vTot;
    return lines * c.hTot;
  endfunction

  // Expected outputs at cycle t since enable, from the requirements
  task automatic checkOne(input bit isTv, input cfg_t c, input int t, input string ctx);
    int x, lines, li, l0, y, fld, aH, d, ex, ey;
    int eh, ev, ed, els, eirq;
    int aOut, aHs, aVs, aDe, aLs, aFld, aIrq, aPx, aPy, aDly;
    string chn;
    chn = isTv ? {ctx, " tv"} : {ctx, " panel"};
    x = t % c.hTot;
    if (c.intl)    lines = c.vTot;
    else if (isTv) lines = c.vTot / 2;
    else           lines = c.vTot;
    li = (t / c.hTot) % lines;
    if (c.intl) begin
      l0  = (c.vTot + 1) / 2;
      fld = (li >= l0) ? 1 : 0;
      y   = (fld != 0) ? li - l0 : li;
      aH  = c.actH / 2;
    end else begin
      fld = 0;
      y   = li;
      aH  = c.actH;
    end
    d    = expDelay(isTv, c);
    eh   = ((x < c.hSw) ? 1 : 0) ^ ((c.hInv != 0 && c.forceHi == 0) ? 1 : 0);
    ev   = ((y < c.vSw) ? 1 : 0) ^ ((c.vInv != 0 && c.forceHi == 0) ? 1 : 0);
    ed   = (x >= c.hBp && x < c.hBp + c.actW && y >= c.vBp && y < c.vBp + aH) ? 1 : 0;
    ex   = (ed != 0) ? x - c.hBp : 0;
    ey   = (ed != 0) ? y - c.vBp : 0;
    els  = (x == d) ? 1 : 0;
    eirq = (c.irq != 0 && x == 0 && y == c.vBp + aH) ? 1 : 0;
    if (isTv) begin
      aOut = int'(tOutEn); aHs = int'(tHs); aVs = int'(tVs); aDe = int'(tDe);
      aLs = int'(tLs); aFld = int'(tFld); aIrq = int'(tIrq);
      aPx = int'(tPixX); aPy = int'(tPixY); aDly = int'(tDly);
    end else begin
      aOut = int'(pOutEn); aHs = int'(pHs); aVs = int'(pVs); aDe = int'(pDe);
      aLs = int'(pLs); aFld = int'(pFld); aIrq = int'(pIrq);
      aPx = int'(pPixX); aPy = int'(pPixY); aDly = int'(pDly);
    end
    chk("R2 outEn", chn, aOut, 1);
    chk("R2/R5 hsync", chn, aHs, eh);
    chk("R4/R5 vsync", chn, aVs, ev);
    chk("R3 de", chn, aDe, ed);
    chk("R3 pixX", chn, aPx, ex);
    chk("R3 pixY", chn, aPy, ey);
    chk("R6 clkDelay", chn, aDly, d);
    chk("R7 lineStart", chn, aLs, els);
    chk("R8 field", chn, aFld, fld);
    chk("R10 vblankIrq", chn, aIrq, eirq);
  endtask

  task automatic checkIdle(input string tag);
    chk(tag, "panel outEn", int'(pOutEn), 0);
    chk(tag, "tv outEn", int'(tOutEn), 0);
    chk(tag, "panel outputs", int'({pHs, pVs, pDe, pLs, pFld, pIrq}), 0);
    chk(tag, "tv outputs", int'({tHs, tVs, tDe, tLs, tFld, tIrq}), 0);
    chk(tag, "panel pix", int'(pPixX) + int'(pPixY), 0);
    chk(tag, "tv pix", int'(tPixX) + int'(tPixY), 0);
  endtask

  task automatic stopAndLoad(input cfg_t c);
    @(negedge clk);
    chanEn = 1'b0;
    @(negedge clk);
    checkIdle("R11 stop");
    cur = c;
    @(negedge clk);
    checkIdle("R1 idle");
    chanEn = 1'b1;
  endtask

  task automatic runCfg(input cfg_t c, input string ctx);
    int n;
    stopAndLoad(c);
    n = 2 * frameCycles(1'b0, c);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      checkOne(1'b0, c, t, ctx);
      checkOne(1'b1, c, t, ctx);
    end
  endtask

  // R9: change mid-frame, new timing only after each channel's frame end
  task automatic runShadow(input cfg_t a, input cfg_t b);
    int fp, ft, n;
    stopAndLoad(a);
    fp = frameCycles(1'b0, a);
    ft = frameCycles(1'b1, a);
    n  = fp + 2 * frameCycles(1'b0, b);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (t < fp) checkOne(1'b0, a, t, "R9 old");
      else        checkOne(1'b0, b, t - fp, "R9 new");
      if (t < ft) checkOne(1'b1, a, t, "R9 old");
      else        checkOne(1'b1, b, t - ft, "R9 new");
      if (t == 50) cur = b;
    end
  endtask

  bit done = 1'b0;

  initial begin
    cfg_t cA, cP1, cP2, cI, cC, cZ, cB;
    cA  = '{actW:8, actH:5, hTot:24, hBp:6, hSw:3, vTot:24, vBp:4, vSw:2,
            hInv:0, vInv:0, forceHi:0, intl:0, irq:1};
    cP1 = cA; cP1.hInv = 1;
    cP2 = cA; cP2.vInv = 1; cP2.irq = 0;
    cI  = '{actW:8, actH:10, hTot:24, hBp:6, hSw:3, vTot:25, vBp:4, vSw:2,
            hInv:0, vInv:0, forceHi:0, intl:1, irq:1};
    cC  = '{actW:20, actH:10, hTot:40, hBp:10, hSw:4, vTot:100, vBp:4, vSw:3,
            hInv:1, vInv:1, forceHi:1, intl:0, irq:0};
    cZ  = '{actW:4, actH:5, hTot:12, hBp:3, hSw:2, vTot:12, vBp:1, vSw:1,
            hInv:0, vInv:0, forceHi:0, intl:0, irq:1};
    cB  = '{actW:6, actH:4, hTot:20, hBp:5, hSw:2, vTot:16, vBp:3, vSw:1,
            hInv:0, vInv:1, forceHi:0, intl:0, irq:1};
    cur = cA;
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    runCfg(cA,  "R2 progressive");
    runCfg(cP1, "R5 hsync invert");
    runCfg(cP2, "R5 vsync invert");
    runCfg(cI,  "R8 interlace");
    runCfg(cC,  "R6 clamp high, R5 force");
    runCfg(cZ,  "R6 floor zero");
    runShadow(cA, cB);
    runCfg(cA,  "R11 restart");

    @(negedge clk);
    chanEn = 1'b0;
    @(negedge clk);
    checkIdle("R11 final stop");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule